// File: doc/BRIEF.md
# Programmable-Modulus Phase Accumulator

This block produces the running phase for a direct digital synthesizer whose output frequency is a rational fraction of the clock, including ratios whose denominator is not a power of two. Each enabled cycle it adds a 20-bit coarse step to a binary coarse accumulator. A 12-bit fine step goes into a separate residue accumulator. When the residue reaches the modulus, it folds back and donates one extra count to the coarse sum. Because the residue folds at a chosen modulus M instead of at 4096, a ratio such as 8/11 closes exactly after 11 cycles, with no long-term drift.

The modulus is programmed as its two's complement: `mod_offset = 4096 - M`. The value zero selects M = 4096. With that setting, the coarse and fine steps together act as one 32-bit binary increment, with the coarse step in the upper 20 bits. The output is the upper 19 bits of the coarse accumulator, taken from a register. The output feeds a phase-to-amplitude stage, which is not part of this block.

Top module: `pmod_phase_acc`

## Requirements
- R1: A rising clock edge with `rst_n` low clears the coarse accumulator, the residue and `phase_word` to zero.
- R2: On an edge where `advance` is low (and `rst_n` is high), the coarse accumulator, the residue and `phase_word` keep their values.
- R3: With `mod_offset` = 0, after each enabled edge `phase_word` equals bits [31:13] of a 32-bit accumulator that adds `{step_coarse, step_fine}` per enabled edge, with `step_fine` in bits [11:0].
- R4: Each enabled edge adds `step_coarse`, plus the wrap carry, to the 20-bit coarse accumulator modulo 2^20. `phase_word` equals accumulator bits [19:1] after the same edge, with no further delay.
- R5: With M = 4096 - `mod_offset`, if residue + `step_fine` >= M, the residue becomes residue + `step_fine` - M and the coarse accumulator receives one extra count on that edge. Otherwise the residue becomes residue + `step_fine` and there is no extra count.
- R6: With `mod_offset` = 4, `step_coarse` = 762600 and `step_fine` = 2976, `phase_word` returns to 0 after every 11 enabled edges from reset and repeats with period 11.
- R7: With `mod_offset` = 1, `step_coarse` = 725937 and `step_fine` = 945, `phase_word` returns to 0 after every 13 enabled edges from reset and repeats with period 13.
- R8: While `step_fine` < M and the configuration is held constant since reset, the residue stays below M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| advance | input | 1 | Accumulate on this edge when high |
| step_coarse | input | 20 | Integer (coarse) phase increment |
| step_fine | input | 12 | Fractional (fine) increment, in units of 1/M of a coarse LSB |
| mod_offset | input | 12 | 4096 minus the residue modulus; zero means binary |
| phase_word | output | 19 | Registered truncated phase |

## Verification
The residue bound and the wrap relation checked by the assertions assume two things: the fine step is smaller than the programmed modulus, and the modulus and fine step change only while reset is held. Otherwise the residue can sit above a newly shrunk modulus. The bench respects both assumptions. It applies each new modulus and fine step with `rst_n` low. It picks fine steps only from zero up to M-1, including the edge values 0, 1, M/2 and M-1. It sweeps moduli from 1 to 4095 and also covers binary mode. Enable is toggled in a fixed pattern so that hold cycles fall between active ones.

// File: rtl/pmacc_pkg.sv
// Package: shared widths for the programmable-modulus phase accumulator.
// Assumes: the phase output is no wider than the coarse accumulator.
package pmacc_pkg;
    localparam int COARSE_W = 20;   // coarse accumulator and step width
    localparam int FINE_W   = 12;   // residue, fine step and modulo width
    localparam int PHASE_W  = 19;   // truncated phase output width
endpackage

// File: rtl/pmacc_residue.sv
// Module: fine residue accumulator with a programmable modulus.
// Adds the fine step to the residue each enabled cycle. When the sum reaches
// M = 2**FINE_W - mod_offset, the residue folds back by M and wrap is raised
// for the coarse accumulator in the same cycle.
// Assumes: step_fine < M and residue < M, so that one fold is enough.
module pmacc_residue #(
    parameter int FINE_W = pmacc_pkg::FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [FINE_W-1:0] step_fine,
    input  logic [FINE_W-1:0] mod_offset,
    output logic              wrap,
    output logic [FINE_W-1:0] resid_q
);
    localparam int SUM_W = FINE_W + 2;

    logic [SUM_W-1:0]  raw_sum;
    logic [SUM_W-1:0]  off_sum;
    logic [FINE_W-1:0] resid_d;

    // Form residue+step and residue+step+offset; any carry past FINE_W means sum >= M.
    always_comb begin
        raw_sum = {2'b00, resid_q} + {2'b00, step_fine};
        off_sum = raw_sum + {2'b00, mod_offset};
        wrap    = |off_sum[SUM_W-1:FINE_W];
        resid_d = wrap ? off_sum[FINE_W-1:0] : raw_sum[FINE_W-1:0];
    end

    // Hold the residue state; clear it on reset and advance it only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resid_q <= '0;
        else if (advance)
            resid_q <= resid_d;
    end
endmodule

// File: rtl/pmacc_coarse.sv
// Module: binary coarse accumulator with a registered truncated output.
// Adds the coarse step plus the carry from the residue each enabled cycle,
// modulo 2**COARSE_W. The output register loads the top PHASE_W bits of the
// next state, so phase_q always matches the accumulator's top bits.
// Assumes: PHASE_W <= COARSE_W.
module pmacc_coarse #(
    parameter int COARSE_W = pmacc_pkg::COARSE_W,
    parameter int PHASE_W  = pmacc_pkg::PHASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [COARSE_W-1:0] step_coarse,
    input  logic                carry_in,
    output logic [COARSE_W-1:0] acc_q,
    output logic [PHASE_W-1:0]  phase_q
);
    logic [COARSE_W-1:0] acc_d;

    // Next coarse value: step plus the one-count carry from the residue.
    always_comb begin
        acc_d = acc_q + step_coarse + {{(COARSE_W-1){1'b0}}, carry_in};
    end

    // Update the accumulator and its truncated copy together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            phase_q <= '0;
        end else if (advance) begin
            acc_q   <= acc_d;
            phase_q <= acc_d[COARSE_W-1 -: PHASE_W];
        end
    end
endmodule

// File: rtl/pmod_phase_acc.sv
// Module: top of the programmable-modulus phase accumulator.
// Connects the residue unit, whose wrap is the carry, to the coarse unit.
// Assumes: mod_offset and step_fine change only under reset, and step_fine < M.
module pmod_phase_acc #(
    parameter int COARSE_W = pmacc_pkg::COARSE_W,
    parameter int FINE_W   = pmacc_pkg::FINE_W,
    parameter int PHASE_W  = pmacc_pkg::PHASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [COARSE_W-1:0] step_coarse,
    input  logic [FINE_W-1:0]   step_fine,
    input  logic [FINE_W-1:0]   mod_offset,
    output logic [PHASE_W-1:0]  phase_word
);
    logic                wrap;
    logic [FINE_W-1:0]   fine_resid;
    logic [COARSE_W-1:0] coarse_acc;

    pmacc_residue #(.FINE_W(FINE_W)) u_resid (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .step_fine  (step_fine),
        .mod_offset (mod_offset),
        .wrap       (wrap),
        .resid_q    (fine_resid)
    );

    pmacc_coarse #(.COARSE_W(COARSE_W), .PHASE_W(PHASE_W)) u_coarse (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .step_coarse (step_coarse),
        .carry_in    (wrap),
        .acc_q       (coarse_acc),
        .phase_q     (phase_word)
    );
endmodule

// File: rtl/pmacc_checker.sv
// Module: property checker for pmod_phase_acc, attached through bind.
// Assumes: configuration changes only under reset and step_fine < M.
module pmacc_checker #(
    parameter int COARSE_W = pmacc_pkg::COARSE_W,
    parameter int FINE_W   = pmacc_pkg::FINE_W,
    parameter int PHASE_W  = pmacc_pkg::PHASE_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                advance,
    input logic [COARSE_W-1:0] step_coarse,
    input logic [FINE_W-1:0]   step_fine,
    input logic [FINE_W-1:0]   mod_offset,
    input logic [PHASE_W-1:0]  phase_word,
    input logic [COARSE_W-1:0] acc_q,
    input logic [FINE_W-1:0]   resid_q
);
    localparam int MW = FINE_W + 1;

    logic [MW-1:0]     modulus;
    logic [MW:0]       fine_total;
    logic              fine_wraps;
    logic [FINE_W-1:0] resid_expect;
    logic [COARSE_W-1:0] extra;

    // Derive the arithmetic modulus and the expected residue update from the ports.
    always_comb begin
        modulus      = {1'b1, {FINE_W{1'b0}}} - {1'b0, mod_offset};
        fine_total   = {2'b00, resid_q} + {2'b00, step_fine};
        fine_wraps   = fine_total >= {1'b0, modulus};
        resid_expect = fine_wraps ? FINE_W'(fine_total - {1'b0, modulus})
                                  : fine_total[FINE_W-1:0];
        extra        = {{(COARSE_W-1){1'b0}}, fine_wraps};
    end

    // R1: reset clears all state and the output
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (phase_word == '0 && acc_q == '0 && resid_q == '0));

    // R2: disabled cycles hold everything
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> (phase_word == $past(phase_word) && acc_q == $past(acc_q)
                      && resid_q == $past(resid_q)));

    // R4: output tracks the accumulator top bits
    assert_phase_matches_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_word == acc_q[COARSE_W-1 -: PHASE_W]);

    // R5: coarse grows by step plus one exactly on a residue fold
    assert_coarse_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (acc_q == $past(acc_q) + $past(step_coarse) + $past(extra)));

    // R5: residue folds back by M when it reaches M
    assert_residue_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (resid_q == $past(resid_expect)));

    // R8: residue remains below the modulus under legal stimulus
    assert_residue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, step_fine} < modulus) |-> ({1'b0, resid_q} < modulus));
endmodule

bind pmod_phase_acc pmacc_checker #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .PHASE_W  (PHASE_W)
) u_pmacc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .step_coarse (step_coarse),
    .step_fine   (step_fine),
    .mod_offset  (mod_offset),
    .phase_word  (phase_word),
    .acc_q       (coarse_acc),
    .resid_q     (fine_resid)
);

// File: tb/pmod_phase_acc_test.sv
// Bench: sweeps binary and modulus configurations against arithmetic models.
module pmod_phase_acc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [19:0] step_coarse = '0;
    logic [11:0] step_fine = '0;
    logic [11:0] mod_offset = '0;
    wire  [18:0] phase_word;

    int errors = 0;
    int checks = 0;

    logic [19:0] m_acc;
    logic [31:0] m32;
    int          m_res;
    int          m_mod;

    pmod_phase_acc uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .step_coarse (step_coarse),
        .step_fine   (step_fine),
        .mod_offset  (mod_offset),
        .phase_word  (phase_word)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One model step: Bresenham residue modulo M plus the binary 32-bit reference.
    task automatic model_step();
        int   s;
        logic c;
        s = m_res + int'(step_fine);
        c = (s >= m_mod);
        if (c) s = s - m_mod;
        m_res = s;
        m_acc = m_acc + step_coarse + {19'd0, c};
        m32   = m32 + {step_coarse, step_fine};
    endtask

    task automatic tick(input logic adv);
        advance = adv;
        @(posedge clk);
        #1;
        if (rst_n && adv) model_step();
    endtask

    // Apply a configuration under reset and confirm the cleared output (R1).
    task automatic configure(input logic [19:0] c, input logic [11:0] f, input logic [11:0] m);
        rst_n       = 1'b0;
        step_coarse = c;
        step_fine   = f;
        mod_offset  = m;
        tick(1'b1);
        check("R1", phase_word, 19'd0);
        rst_n = 1'b1;
        m_acc = '0;
        m32   = '0;
        m_res = 0;
        m_mod = 4096 - int'(m);
    endtask

    task automatic period_test(input string req, input logic [19:0] c, input logic [11:0] f,
                               input logic [11:0] m, input int per);
        logic [18:0] hist [0:63];
        configure(c, f, m);
        hist[0] = phase_word;
        for (int k = 1; k <= 3 * per; k++) begin
            tick(1'b1);
            hist[k] = phase_word;
            check(req, phase_word, m_acc[19:1]);
            if (k % per == 0) check(req, phase_word, 19'd0);
            if (k >= per) check(req, phase_word, hist[k - per]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int mods [6] = '{1, 4, 100, 1000, 2731, 4095};
        logic [31:0] bin_steps [5] = '{32'h0000_1000, 32'h0000_0001, 32'hFFFF_FFFF,
                                        32'h8000_0800, 32'h1234_5ABC};

        // R1: output is zero while reset is held
        tick(1'b0);
        check("R1", phase_word, 19'd0);

        // R3, R4: binary mode as one 32-bit increment
        for (int i = 0; i < 5; i++) begin
            configure(bin_steps[i][31:12], bin_steps[i][11:0], 12'd0);
            for (int k = 0; k < 40; k++) begin
                tick(1'b1);
                check("R3", phase_word, m32[31:13]);
            end
        end

        // R2: enable gaps hold the output between active edges
        configure(20'd123457, 12'd3001, 12'd0);
        for (int k = 0; k < 60; k++) begin
            tick((k % 3) != 0);
            check("R2", phase_word, m32[31:13]);
        end

        // R5, R8: modulus sweep across fine-step edge values
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 4; j++) begin
                int mm;
                int fs;
                mm = 4096 - mods[i];
                case (j)
                    0: fs = 0;
                    1: fs = (mm > 1) ? 1 : 0;
                    2: fs = mm - 1;
                    default: fs = mm / 2;
                endcase
                configure(20'(1000 + 77777 * (i + j)), 12'(fs), 12'(mods[i]));
                for (int k = 0; k < 24; k++) begin
                    tick((k % 5) != 4);
                    check("R5", phase_word, m_acc[19:1]);
                end
            end
        end

        // R6: ratio 8/11 closes exactly
        period_test("R6", 20'd762600, 12'd2976, 12'd4, 11);
        // R7: ratio 9/13 closes exactly
        period_test("R7", 20'd725937, 12'd945, 12'd1, 13);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule